// File: doc/BRIEF.md
# Legacy Interrupt Mask and Vector Unit

This block gathers sixteen interrupt request lines from legacy peripherals into one interrupt signal for a processor. Each line's rising edge sets a pending bit. The pending bits are combined with an enable mask, and the result drives a single interrupt output and a vector that names the pending and enabled line with the lowest index.

Software reaches the block through two byte-wide register windows. One window serves lines 7 to 0 and the other serves lines 15 to 8. In each window, offset 1 is the mask port. A write there stores the complement of the data byte into that window's half of the enable mask, so a 1 in the data disables the line. Offset 0 is the end-of-interrupt port. Any write there, whatever the data, clears the whole pending half that belongs to the window. Reads of the mask port return the full 16-bit mask. The vector and the interrupt output are available on dedicated ports at all times.

Top module: `isa_irq_agg`

## Requirements
- R1: After reset the enable mask is 0xFFFF (all lines enabled), no line is pending, `irq_out` is 0 and `vec_out` is 0.
- R2: A write with `bus_sel_lo`=1, `bus_sel_hi`=0 and `bus_off`=1 stores the bitwise complement of `bus_wdata` into mask bits 7:0 and leaves bits 15:8 unchanged.
- R3: A write with `bus_sel_hi`=1, `bus_sel_lo`=0 and `bus_off`=1 stores the complement of `bus_wdata` into mask bits 15:8 and leaves bits 7:0 unchanged.
- R4: While `bus_off`=1 and either select is high, `bus_rdata` shows the full 16-bit mask. In every other case it shows 0.
- R5: Any write with `bus_sel_lo`=1 and `bus_off`=0 clears pending bits 7:0, whatever the data value. Bits 15:8 are not touched.
- R6: Any write with `bus_sel_hi`=1 and `bus_off`=0 clears pending bits 15:8. Bits 7:0 are not touched.
- R7: `vec_out` is the index of the lowest set bit of (pending AND mask), or 0 when that set is empty.
- R8: `irq_out` is 1 exactly when (pending AND mask) is nonzero.
- R9: A pending bit is set by a 0-to-1 transition on its request line. It stays set until an end-of-interrupt clears it. A request that is held high does not set the bit again.
- R10: If a rising edge arrives in the same cycle as an end-of-interrupt for its half, the line remains pending.
- R11: A masked line still becomes pending. Re-enabling it makes it visible on `irq_out` and `vec_out`.
- R12: A write with both selects high acts on both halves at once. With `bus_off`=1 it loads the complemented byte into both mask halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_req | input | 16 | Request lines, one per source |
| bus_sel_lo | input | 1 | Selects the window for lines 7:0 |
| bus_sel_hi | input | 1 | Selects the window for lines 15:8 |
| bus_off | input | 1 | Register offset within the window: 0 = end-of-interrupt, 1 = mask |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 16 | Read data: the enable mask at offset 1, otherwise 0 |
| vec_out | output | 4 | Lowest pending and enabled line index, or 0 |
| irq_out | output | 1 | High while any enabled line is pending |

## Verification
The bench holds a request line high across an end-of-interrupt. A design that detected levels instead of edges would set that line pending again straight away. It writes mask bytes to each window in turn and reads the mask back. This catches a design that stores the byte without inverting it, or that overwrites the other half. It raises a line in the same cycle as the end-of-interrupt for that half, where a design that gives the clear priority would lose the request. It also lets masked lines become pending and then unmasks them. A design that gated the latch with the mask would then never raise the interrupt.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;
  localparam int unsigned LINES_DEF = 16;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/isa_irq_pend.sv
module isa_irq_pend #(
  parameter int unsigned NLINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req,
  input  logic              clr_lo,
  input  logic              clr_hi,
  output logic [NLINES-1:0] pend
);
  localparam int unsigned HALF = NLINES / 2;

  logic [NLINES-1:0] req_q;
  logic [NLINES-1:0] rise;
  logic [NLINES-1:0] clr_vec;
  logic [NLINES-1:0] pend_d;
  logic              pend_en;

  always_comb begin
    rise    = req & ~req_q;
    clr_vec = {{(NLINES-HALF){clr_hi}}, {HALF{clr_lo}}};
    // a fresh edge overrides a clear in the same cycle
    pend_d  = (pend & ~clr_vec) | rise;
    pend_en = (|rise) | clr_lo | clr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (pend_en) begin
      pend <= pend_d;
    end
  end

  a_r5_eoi_lo_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lo |=> ((pend[HALF-1:0] & ~$past(rise[HALF-1:0])) == '0));

  a_r6_eoi_hi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hi |=> ((pend[NLINES-1:HALF] & ~$past(rise[NLINES-1:HALF])) == '0));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_lo || clr_hi) |=> (($past(pend) & ~pend) == '0));

  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));
endmodule

// File: rtl/isa_irq_mask.sv
module isa_irq_mask #(
  parameter int unsigned NLINES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [NLINES/2-1:0]   wdata,
  output logic [NLINES-1:0]     mask
);
  localparam int unsigned HALF = NLINES / 2;

  logic [NLINES-1:0] mask_d;
  logic              mask_en;

  always_comb begin
    mask_d  = mask;
    mask_en = wr_lo | wr_hi;
    if (wr_lo) mask_d[HALF-1:0]      = ~wdata;
    if (wr_hi) mask_d[NLINES-1:HALF] = ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (mask_en) begin
      mask <= mask_d;
    end
  end

  a_r2_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (mask[HALF-1:0] == ~$past(wdata)) &&
                           (mask[NLINES-1:HALF] == $past(mask[NLINES-1:HALF])));

  a_r3_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (mask[NLINES-1:HALF] == ~$past(wdata)) &&
                           (mask[HALF-1:0] == $past(mask[HALF-1:0])));

  a_r12_both_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && wr_lo) |=> (mask == {~$past(wdata), ~$past(wdata)}));
endmodule

// File: rtl/isa_irq_prio.sv
module isa_irq_prio #(
  parameter int unsigned NLINES = 16,
  parameter int unsigned IDXW   = 4
) (
  input  logic [NLINES-1:0] act,
  output logic [IDXW-1:0]   vec,
  output logic              any
);
  always_comb begin
    vec = '0;
    any = |act;
    // scan downward so the lowest set index is the one that remains
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (act[i]) vec = IDXW'(i);
    end
  end
endmodule

// File: rtl/isa_irq_agg.sv
module isa_irq_agg
  import isa_irq_pkg::*;
#(
  parameter int unsigned NLINES = LINES_DEF,
  localparam int unsigned HALF  = NLINES / 2,
  localparam int unsigned IDXW  = idx_width(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_req,
  input  logic              bus_sel_lo,
  input  logic              bus_sel_hi,
  input  logic              bus_off,
  input  logic              bus_wr,
  input  logic [HALF-1:0]   bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  output logic [IDXW-1:0]   vec_out,
  output logic              irq_out
);
  logic [1:0]        rst_sync;
  logic              rst_ni;
  logic              wr_lo, wr_hi;
  logic              eoi_lo, eoi_hi;
  logic              mwr_lo, mwr_hi;
  logic [NLINES-1:0] pend;
  logic [NLINES-1:0] mask;
  logic [NLINES-1:0] act;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync[1];

  always_comb begin
    wr_lo  = bus_wr & bus_sel_lo;
    wr_hi  = bus_wr & bus_sel_hi;
    eoi_lo = wr_lo & ~bus_off;
    eoi_hi = wr_hi & ~bus_off;
    mwr_lo = wr_lo & bus_off;
    mwr_hi = wr_hi & bus_off;
    bus_rdata = (bus_off && (bus_sel_lo || bus_sel_hi)) ? mask : '0;
    act = pend & mask;
  end

  isa_irq_pend #(.NLINES(NLINES)) u_pend (
    .clk    (clk),
    .rst_n  (rst_ni),
    .req    (irq_req),
    .clr_lo (eoi_lo),
    .clr_hi (eoi_hi),
    .pend   (pend)
  );

  isa_irq_mask #(.NLINES(NLINES)) u_mask (
    .clk   (clk),
    .rst_n (rst_ni),
    .wr_lo (mwr_lo),
    .wr_hi (mwr_hi),
    .wdata (bus_wdata),
    .mask  (mask)
  );

  isa_irq_prio #(.NLINES(NLINES), .IDXW(IDXW)) u_prio (
    .act (act),
    .vec (vec_out),
    .any (irq_out)
  );

  always_comb begin
    if (rst_ni === 1'b1) begin
      if (vec_out != '0) begin
        a_r7_vec_is_active: assert (act[vec_out]);
      end
      a_r8_irq_matches_vec: assert (irq_out == ((vec_out != '0) || act[0]));
    end
  end

  a_r1_no_irq_without_pend: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend == '0) |-> !irq_out);
endmodule

// File: tb/isa_irq_agg_test.sv
module isa_irq_agg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] irq_req;
  logic        bus_sel_lo, bus_sel_hi, bus_off, bus_wr;
  logic [7:0]  bus_wdata;
  logic [15:0] bus_rdata;
  logic [3:0]  vec_out;
  logic        irq_out;

  isa_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_sel_lo(bus_sel_lo), .bus_sel_hi(bus_sel_hi), .bus_off(bus_off),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vec_out(vec_out), .irq_out(irq_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // scoreboard
  logic        q_irq[$];
  logic [3:0]  q_vec[$];
  logic [15:0] q_rd[$];
  string       q_tag[$];
  event        chk_ev;

  // reference model state
  logic [15:0] m_pend, m_mask, m_prev;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] low_idx(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic push_exp(input string tag);
    logic [15:0] a;
    a = m_pend & m_mask;
    q_irq.push_back(a != 0);
    q_vec.push_back(low_idx(a));
    q_rd.push_back((bus_off && (bus_sel_lo || bus_sel_hi)) ? m_mask : 16'h0);
    q_tag.push_back(tag);
    -> chk_ev;
  endtask

  // one clock: apply inputs at negedge, update model at posedge, check after
  task automatic cyc(input logic [15:0] req, input logic wr, input logic lo,
                     input logic hi, input logic off, input logic [7:0] d,
                     input string tag);
    logic [15:0] rise, clr;
    @(negedge clk);
    irq_req = req; bus_wr = wr; bus_sel_lo = lo; bus_sel_hi = hi;
    bus_off = off; bus_wdata = d;
    @(posedge clk);
    rise = req & ~m_prev;
    clr  = {{8{wr & hi & ~off}}, {8{wr & lo & ~off}}};
    m_pend = (m_pend & ~clr) | rise;
    if (wr && off && lo) m_mask[7:0]  = ~d;
    if (wr && off && hi) m_mask[15:8] = ~d;
    m_prev = req;
    #1;
    bus_wr = 0;
    push_exp(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      while (q_tag.size() > 0) begin
        logic e_irq; logic [3:0] e_vec; logic [15:0] e_rd; string t;
        e_irq = q_irq.pop_front(); e_vec = q_vec.pop_front();
        e_rd = q_rd.pop_front(); t = q_tag.pop_front();
        checks++;
        if (irq_out !== e_irq || vec_out !== e_vec || bus_rdata !== e_rd) begin
          errors++;
          $display("FAIL %s: irq=%0b vec=%0d rdata=%h expected irq=%0b vec=%0d rdata=%h",
                   t, irq_out, vec_out, bus_rdata, e_irq, e_vec, e_rd);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    irq_req = 0; bus_wr = 0; bus_sel_lo = 0; bus_sel_hi = 0; bus_off = 0;
    bus_wdata = 0; rst_n = 0;
    m_pend = 0; m_mask = 16'hFFFF; m_prev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state, also read mask
    bus_sel_lo = 1; bus_off = 1;
    #1 push_exp("R1 reset mask and outputs");
    cyc(16'h0000, 0, 1, 0, 1, 8'h00, "R4 mask readback after reset");
    // R9 edge latch, R7 R8
    cyc(16'h0020, 0, 0, 0, 0, 8'h00, "R9 R7 R8 line 5 edge");
    cyc(16'h0024, 0, 0, 0, 0, 8'h00, "R7 lower line 2 wins");
    // R5 eoi low with lines held high; no re-latch
    cyc(16'h0024, 1, 1, 0, 0, 8'h5A, "R5 eoi low clears");
    cyc(16'h0024, 0, 0, 0, 0, 8'h00, "R9 held level does not re-set");
    cyc(16'h1000, 0, 0, 0, 0, 8'h00, "R9 line 12 edge");
    cyc(16'h1000, 1, 1, 0, 0, 8'h00, "R5 eoi low leaves high half");
    // R3 high mask write disables line 12
    cyc(16'h0000, 1, 0, 1, 1, 8'h10, "R3 high mask write");
    cyc(16'h0000, 0, 0, 1, 1, 8'h00, "R4 read mask via high window");
    cyc(16'h0000, 1, 1, 0, 1, 8'h01, "R2 low mask write");
    // R11 masked line still latches
    cyc(16'h0001, 0, 0, 0, 0, 8'h00, "R11 masked line 0 latched silently");
    cyc(16'h0009, 0, 0, 0, 0, 8'h00, "R7 line 3 visible");
    cyc(16'h0009, 1, 0, 1, 1, 8'h00, "R11 unmask high half");
    cyc(16'h0009, 1, 1, 0, 1, 8'h00, "R11 unmask line 0 gives vec 0");
    // R10 rise coinciding with eoi high
    cyc(16'h0209, 1, 0, 1, 0, 8'hFF, "R10 edge wins over eoi, R6");
    cyc(16'h0209, 1, 1, 0, 0, 8'h20, "R5 eoi low leaves line 9");
    cyc(16'h0000, 1, 0, 1, 0, 8'h00, "R6 eoi high clears");
    cyc(16'h0081, 0, 0, 0, 0, 8'h00, "R7 lines 0 and 7");
    // R12 both halves masked at once
    cyc(16'h0081, 1, 1, 1, 1, 8'hFF, "R12 both windows mask all");
    cyc(16'h8081, 0, 0, 0, 0, 8'h00, "R11 line 15 pends masked");
    cyc(16'h8081, 1, 1, 1, 1, 8'h7F, "R12 both windows enable bit 7 of each");
    cyc(16'h8081, 0, 0, 0, 1, 8'h00, "R4 rdata zero with no select");
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule